// File: doc/BRIEF.md
# Prioritized Interrupt Status Controller

This block gathers up to 32 interrupt sources into a single sticky status word. Each source bit is set by a one-cycle event on its input line, or by software through a pending-set register. A fixed-priority encoder reports the index of the pending source that wins: bit 0 beats every other bit, and bit 31 loses to all of them. Software clears serviced sources by writing ones to the status register.

A routing control chooses where a pending interrupt goes. In local mode the block drives a level interrupt output while any status bit is set. In remote mode that output stays low. Instead, each new set event raises a request toward a link transmitter, and the request stays up until the transmitter acknowledges it. A pointer register holds the destination address that the transmitter puts in the interrupt message. Link error events reach the status word only when an error-enable control is set.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While any status bit is set, bits 4:0 of the vector register (word 1) read the lowest index among the set status bits, and bit 31 reads 0.
- R2: The vector register reads 32'h8000_0000 when no status bit is set. Its bits 30:5 always read zero. A write to word 1 changes no register.
- R3: Writing the status register (word 2) clears every bit written as 1 and leaves every bit written as 0 unchanged. A read of word 2 returns the status.
- R4: A pulse on `src_evt[k]` sets status bit k on the next clock edge. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: Writing the pending-set register (word 3) sets every status bit written as 1. Word 3 reads as zero.
- R6: When control bit 0 (word 0) is 1, `irq_local` is high exactly while any status bit is set, and `msg_req` does not rise.
- R7: When control bit 0 is 0, `irq_local` is low. A set event raises `msg_req` at the next edge. `msg_req` then holds until a cycle in which `msg_ack` is high, and after that it stays low until another set event, even while status bits stay pending.
- R8: A pulse on `err_evt` sets status bit 31 only while control bit 1 is 1. While that bit is 0, the pulse has no effect.
- R9: Bits 31:2 of the pointer register (word 4) are read/write and bits 1:0 read zero. `msg_ptr` always shows the register value.
- R10: After reset the control, status and pointer registers hold zero, and `irq_local` and `msg_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 32 | Per-source set events |
| err_evt | input | 1 | Link error event, gated by control bit 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq_local | output | 1 | Local interrupt level |
| msg_req | output | 1 | Request to send a remote interrupt message |
| msg_ack | input | 1 | Transmitter acknowledge of `msg_req` |
| msg_ptr | output | 32 | Destination address for the remote message |

## Verification
The assertions check four things on every cycle:
- a set bit stays set;
- a cleared bit drops unless an event sets it again;
- the encoder output always points at a set bit with no lower set bit below it;
- `msg_req` holds until acknowledged, drops after the acknowledge, and never rises without a remote-mode set event.

Only the bench scenarios can show the rest:
- the vector value for each status pattern;
- the outcome when a clear and an event collide;
- the read-zero and write-ignore behaviour of individual registers;
- gating of error events;
- the full request and acknowledge sequence.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned DW     = 32;
  localparam int unsigned VEC_W  = 5;

  typedef enum logic [REG_AW-1:0] {
    A_CFG  = 3'd0,
    A_VEC  = 3'd1,
    A_STAT = 3'd2,
    A_PSET = 3'd3,
    A_PTR  = 3'd4
  } reg_addr_e;

  // Index of the lowest set bit; zero when none is set.
  function automatic logic [VEC_W-1:0] lowest_set(input logic [DW-1:0] v);
    logic [VEC_W-1:0] idx;
    idx = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (v[i]) idx = VEC_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [DW-1:0] vec_word(input logic [VEC_W-1:0] idx, input logic none);
    return {none, {(DW-VEC_W-1){1'b0}}, idx};
  endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] status,
  output logic         set_any,
  output logic         any_pend
);
  logic [N-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_mask) | set_mask;
  end

  assign status   = status_q;
  assign set_any  = |set_mask;
  assign any_pend = |status_q;

  // R4: every bit set in a cycle is present afterwards
  p_set_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_any |=> ((status_q & $past(set_mask)) == $past(set_mask)));
  // R3: cleared bits without a coincident set drop
  p_clear_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((status_q & $past(clr_mask) & ~$past(set_mask)) == '0));
  // R3/R4: bits untouched by set or clear hold their value
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(set_mask) & ~$past(clr_mask)) ==
              ($past(status_q) & ~$past(set_mask) & ~$past(clr_mask))));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     status,
  output logic [VEC_W-1:0] vec,
  output logic             none
);
  logic [DW-1:0] wide;

  assign wide = DW'(status);
  assign vec  = lowest_set(wide);
  assign none = (wide == '0);

  // R1: the vector names a set bit and no lower bit is set
  p_vec_winner_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !none |-> (wide[vec] && ((wide & ((DW'(1) << vec) - DW'(1))) == '0)));
  // R2: an empty status always reports vector zero
  p_empty_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    none |-> (vec == '0));
endmodule

// File: rtl/irq_route.sv
module irq_route (
  input  logic clk,
  input  logic rst_n,
  input  logic route_local,
  input  logic set_any,
  input  logic any_pend,
  input  logic msg_ack,
  output logic irq_local,
  output logic msg_req
);
  logic remote_evt;
  logic req_q;

  assign remote_evt = set_any && !route_local;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= remote_evt || (req_q && !msg_ack);
  end

  assign msg_req   = req_q;
  assign irq_local = route_local && any_pend;

  // R7: request holds until acknowledged
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req && !msg_ack) |=> msg_req);
  // R7: acknowledge without a new event drops the request
  p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req && msg_ack && !remote_evt) |=> !msg_req);
  // R6/R7: request only rises after a remote-mode set event
  p_req_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_req) |-> $past(remote_evt));
  // R6: remote mode never drives the local line
  p_remote_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !route_local |-> !irq_local);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NSRC    = 32,
  parameter int unsigned ERR_BIT = NSRC - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_evt,
  input  logic              err_evt,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_local,
  output logic              msg_req,
  input  logic              msg_ack,
  output logic [DW-1:0]     msg_ptr
);
  localparam int unsigned PTR_LSB = 2;

  logic              route_local_q;
  logic              err_en_q;
  logic [DW-1:PTR_LSB] ptr_q;

  logic wr_cfg, wr_stat, wr_pset, wr_ptr;
  logic [NSRC-1:0]  set_mask, clr_mask, err_mask, status;
  logic             set_any, any_pend, none;
  logic [VEC_W-1:0] vec;

  assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_pset = reg_wr && (reg_addr == A_PSET);
  assign wr_ptr  = reg_wr && (reg_addr == A_PTR);

  assign err_mask = (err_evt && err_en_q) ? (NSRC'(1) << ERR_BIT) : '0;
  assign set_mask = src_evt | err_mask | (wr_pset ? reg_wdata[NSRC-1:0] : '0);
  assign clr_mask = wr_stat ? reg_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_local_q <= 1'b0;
      err_en_q      <= 1'b0;
      ptr_q         <= '0;
    end else begin
      if (wr_cfg) begin
        route_local_q <= reg_wdata[0];
        err_en_q      <= reg_wdata[1];
      end
      if (wr_ptr) ptr_q <= reg_wdata[DW-1:PTR_LSB];
    end
  end

  irq_status_bank #(.N(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
    .status(status), .set_any(set_any), .any_pend(any_pend)
  );

  irq_prio_enc #(.N(NSRC)) u_enc (
    .clk(clk), .rst_n(rst_n), .status(status), .vec(vec), .none(none)
  );

  irq_route u_route (
    .clk(clk), .rst_n(rst_n), .route_local(route_local_q), .set_any(set_any),
    .any_pend(any_pend), .msg_ack(msg_ack), .irq_local(irq_local), .msg_req(msg_req)
  );

  assign msg_ptr = {ptr_q, {PTR_LSB{1'b0}}};

  always_comb begin
    unique case (reg_addr)
      A_CFG:   reg_rdata = {{(DW-2){1'b0}}, err_en_q, route_local_q};
      A_VEC:   reg_rdata = vec_word(vec, none);
      A_STAT:  reg_rdata = DW'(status);
      A_PTR:   reg_rdata = msg_ptr;
      default: reg_rdata = '0;
    endcase
  end

  // R8: with error gating off, an error event alone never sets the error bit
  p_err_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !err_en_q && !src_evt[ERR_BIT] && !wr_pset && !status[ERR_BIT])
      |=> !status[ERR_BIT]);
  // R2: writes to the vector word leave the status alone
  p_vec_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_VEC && src_evt == '0 && !err_evt) |=> $stable(status));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_evt = '0;
  logic        err_evt = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_local, msg_req, msg_ack;
  logic [31:0] msg_ptr;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  initial msg_ack = 1'b0;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .err_evt(err_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_local(irq_local), .msg_req(msg_req),
    .msg_ack(msg_ack), .msg_ptr(msg_ptr)
  );

  localparam logic [2:0] CFG = 3'd0, VEC = 3'd1, STAT = 3'd2, PSET = 3'd3, PTR = 3'd4;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected vector word computed by scanning upward for the first one.
  function automatic logic [31:0] exp_vec(input logic [31:0] s);
    if (s == 0) return 32'h8000_0000;
    for (int i = 0; i < 32; i++) if (s[i]) return i;
    return 0;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    rd(CFG, d);  chk("R10 cfg", d, 0);
    rd(STAT, d); chk("R10 stat", d, 0);
    rd(PTR, d);  chk("R10 ptr", d, 0);
    rd(VEC, d);  chk("R2 vec empty at reset", d, 32'h8000_0000);
    chk("R10 irq_local", irq_local, 0);
    chk("R10 msg_req", msg_req, 0);

    wr(CFG, 32'h1);
    // R1 single-bit sweep, R6 local routing
    for (int k = 0; k < 32; k++) begin
      wr(PSET, 32'h1 << k);
      rd(VEC, d); chk("R1 single vec", d, k);
      chk("R6 irq_local on", irq_local, 1);
      chk("R6 no msg_req", msg_req, 0);
      wr(STAT, 32'hFFFF_FFFF);
      rd(VEC, d); chk("R2 vec empty", d, 32'h8000_0000);
      chk("R6 irq_local off", irq_local, 0);
    end
    // R1 multi-bit patterns
    for (int k = 0; k < 32; k++) begin
      pat = (32'h8000_0000 >> (k / 2)) | (32'h1 << k) | (32'h4000_0000 >> ((k * 7) % 31));
      wr(PSET, pat);
      rd(STAT, d); chk("R5 pset pattern", d, pat);
      rd(VEC, d);  chk("R1 pattern vec", d, exp_vec(pat));
      rd(PSET, d); chk("R5 pset reads zero", d, 0);
      wr(STAT, 32'hFFFF_FFFF);
    end
    // R3 walk clears from all ones
    wr(PSET, 32'hFFFF_FFFF);
    wr(STAT, 32'h0);
    rd(STAT, d); chk("R3 zero write keeps", d, 32'hFFFF_FFFF);
    pat = 32'hFFFF_FFFF;
    for (int k = 0; k < 32; k++) begin
      rd(VEC, d); chk("R1 walk vec", d, exp_vec(pat));
      wr(STAT, 32'h1 << k);
      pat = pat & ~(32'h1 << k);
      rd(STAT, d); chk("R3 w1c", d, pat);
    end
    // R2 vector is read-only
    wr(PSET, 32'h0000_0300);
    wr(VEC, 32'hFFFF_FFFF);
    rd(STAT, d); chk("R2 vec write ignored stat", d, 32'h0000_0300);
    rd(VEC, d);  chk("R2 vec write ignored vec", d, 8);
    wr(STAT, 32'hFFFF_FFFF);
    // R4 event beats clear, neighbour still cleared
    wr(PSET, 32'h60);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = STAT; reg_wdata = 32'h60; src_evt = 32'h20;
    @(negedge clk);
    reg_wr = 1'b0; src_evt = '0;
    rd(STAT, d); chk("R4 set beats clear", d, 32'h20);
    wr(STAT, 32'hFFFF_FFFF);
    // R4 plain event
    @(negedge clk); src_evt = 32'h0001_0000;
    @(negedge clk); src_evt = '0;
    rd(STAT, d); chk("R4 src event", d, 32'h0001_0000);
    wr(STAT, 32'hFFFF_FFFF);
    // R8 error gating
    @(negedge clk); err_evt = 1'b1;
    @(negedge clk); err_evt = 1'b0;
    rd(STAT, d); chk("R8 err gated off", d, 0);
    wr(CFG, 32'h3);
    @(negedge clk); err_evt = 1'b1;
    @(negedge clk); err_evt = 1'b0;
    rd(STAT, d); chk("R8 err enabled", d, 32'h8000_0000);
    rd(VEC, d);  chk("R8 err vec", d, 31);
    wr(STAT, 32'hFFFF_FFFF);
    // R9 pointer
    wr(PTR, 32'hDEAD_BEEF);
    rd(PTR, d); chk("R9 ptr read", d, 32'hDEAD_BEEC);
    chk("R9 msg_ptr", msg_ptr, 32'hDEAD_BEEC);
    // R7 remote routing
    wr(CFG, 32'h0);
    chk("R7 idle req", msg_req, 0);
    wr(PSET, 32'h8);
    chk("R7 req raised", msg_req, 1);
    chk("R7 irq_local low", irq_local, 0);
    @(negedge clk); @(negedge clk);
    chk("R7 req held", msg_req, 1);
    msg_ack = 1'b1;
    @(negedge clk);
    msg_ack = 1'b0;
    chk("R7 req dropped", msg_req, 0);
    repeat (3) @(negedge clk);
    chk("R7 no re-raise", msg_req, 0);
    rd(STAT, d); chk("R7 status still pending", d, 32'h8);
    src_evt = 32'h4;
    @(negedge clk);
    src_evt = '0;
    chk("R7 new event raises", msg_req, 1);
    msg_ack = 1'b1; src_evt = 32'h2;
    @(negedge clk);
    msg_ack = 1'b0; src_evt = '0;
    chk("R7 ack with new event keeps", msg_req, 1);
    msg_ack = 1'b1;
    @(negedge clk);
    msg_ack = 1'b0;
    chk("R7 final drop", msg_req, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule